// File: doc/BRIEF.md
# Host-Target Command Mailbox

The mailbox is a small memory-mapped block through which a target processor passes commands to its host environment. It holds two 64-bit registers, a target-to-host command word and a host-to-target reply word. Each is reached as two 32-bit halves over a simple single-cycle register port. Writing the upper half of the command word commits a command. The committed word is split into an 8-bit device field and an 8-bit command field, and the block then acts on it.

Three commands are understood. A command word equal to exactly one requests power-off and raises a halt flag that stays set until reset. Device 1 with command 1 sends the low byte of the word to a console byte stream under a valid/ready handshake. When the sink takes the byte, the command word is cleared and an acknowledgement is placed in the reply word. Device 1 with command 0 is a keyboard request that only clears the command word. Every other committed value stays in the register and produces a one-cycle unsupported-command pulse.

Top module: `hostmbox`

## Requirements
- R1: Offset 0 reads the low and offset 4 the high half of the command word. Offsets 8 and 12 read the low and high halves of the reply word. Every other offset reads zero. The read data is combinational from the address.
- R2: A 32-bit write to offset 0, 8 or 12 changes only the addressed half. It raises no halt, no console byte and no unsupported pulse.
- R3: A commit (a write to offset 4) whose resulting 64-bit word equals exactly 1 sets `halt` one cycle later. `halt` stays set until reset, and a committed value of 2 does not set it.
- R4: A commit with device bits 63:56 = 1 and command bits 55:48 = 1 raises `con_valid` in the following cycle, with `con_data` equal to bits 7:0 of the word. Both hold while `con_ready` is low, and the command word keeps its committed value meanwhile.
- R5: In the cycle after `con_valid` and `con_ready` are both high, `con_valid` is low, the command word is zero and the reply word is 0x0101_0000_0000_0000.
- R6: A commit with device 1 and command 0 clears the whole command word. It leaves the reply word unchanged and raises no console byte.
- R7: Any other commit keeps the written word in the command register and leaves the reply word unchanged. It drives `unsup` high for exactly the one cycle after the write.
- R8: While a console byte is pending (`busy` high), every register write is ignored, including one in the same cycle the byte is accepted.
- R9: Only accesses with `reg_size` = 2 (4 bytes) are used. Writes of other sizes change nothing, and reads of other sizes return zero.
- R10: Synchronous active-low reset clears both registers, `halt`, `unsup` and any pending console byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Write strobe |
| reg_addr | input | 4 | Byte offset of the access |
| reg_size | input | 2 | Log2 of the access size in bytes; 2 is the only accepted value |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| busy | output | 1 | A console byte is pending; writes are ignored |
| con_valid | output | 1 | Console byte available |
| con_data | output | 8 | Console byte |
| con_ready | input | 1 | Console sink accepts the byte |
| halt | output | 1 | Sticky power-off request |
| unsup | output | 1 | One-cycle pulse after an unsupported commit |

## Verification
Two events can meet in one cycle: the console sink accepts a pending byte, which rewrites both registers, while a register write arrives on the port. The bench holds `con_ready` low so that a byte stays pending. It then raises `con_ready` on the same clock edge that it presents a write to the reply word's high half. The write must lose: the reply word must read back exactly the acknowledgement value, and the command word must read zero. Earlier writes made while the byte was stalled are checked to have no effect in the same way.

// File: rtl/hostmbox_pkg.sv
// Shared constants and types for the host-target command mailbox.
package hostmbox_pkg;
    localparam int HALF_W  = 32;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int FIELD_W = 8;
    localparam int DEV_LSB = WORD_W - FIELD_W;
    localparam int CMD_LSB = DEV_LSB - FIELD_W;

    localparam int OFF_TH_LO = 0;
    localparam int OFF_TH_HI = 4;
    localparam int OFF_FH_LO = 8;
    localparam int OFF_FH_HI = 12;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    localparam logic [FIELD_W-1:0] DEV_CONSOLE = 8'd1;
    localparam logic [FIELD_W-1:0] CMD_PUTC    = 8'd1;
    localparam logic [FIELD_W-1:0] CMD_KBD     = 8'd0;

    typedef enum logic [1:0] {
        ACT_HALT = 2'd0,
        ACT_PUTC = 2'd1,
        ACT_KBD  = 2'd2,
        ACT_BAD  = 2'd3
    } mbox_act_e;
endpackage

// File: rtl/hostmbox_decode.sv
// Command decoder: classifies a committed 64-bit command word.
// Assumes the word presented is the value the register takes after the commit.
module hostmbox_decode
    import hostmbox_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output mbox_act_e         act
);
    logic [FIELD_W-1:0] dev;
    logic [FIELD_W-1:0] cmd;

    assign dev = word[DEV_LSB +: FIELD_W];
    assign cmd = word[CMD_LSB +: FIELD_W];

    // Pick the action; power-off takes precedence because it is an exact match.
    always_comb begin
        if (word == WORD_W'(1))
            act = ACT_HALT;
        else if (dev == DEV_CONSOLE && cmd == CMD_PUTC)
            act = ACT_PUTC;
        else if (dev == DEV_CONSOLE && cmd == CMD_KBD)
            act = ACT_KBD;
        else
            act = ACT_BAD;
    end
endmodule

// File: rtl/hostmbox_console.sv
// Console output stage: holds one byte under a valid/ready handshake.
// Assumes load is never asserted while a byte is already pending.
module hostmbox_console
    import hostmbox_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FIELD_W-1:0] load_byte,
    input  logic               con_ready,
    output logic               con_valid,
    output logic [FIELD_W-1:0] con_data,
    output logic               accept
);
    assign accept = con_valid && con_ready;

    // Pending flag: set by a load, cleared when the sink takes the byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            con_valid <= 1'b0;
        else if (load)
            con_valid <= 1'b1;
        else if (accept)
            con_valid <= 1'b0;
    end

    // Byte holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            con_data <= '0;
        else if (load)
            con_data <= load_byte;
    end
endmodule

// File: rtl/hostmbox_rdmux.sv
// Read multiplexer: returns the addressed 32-bit half, zero elsewhere.
// Assumes the access size has already been qualified by the caller.
module hostmbox_rdmux
    import hostmbox_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [WORD_W-1:0] tohost,
    input  logic [WORD_W-1:0] fromhost,
    input  logic              rd_ok,
    input  logic [ADDR_W-1:0] addr,
    output logic [HALF_W-1:0] rdata
);
    // Select the half named by the offset.
    always_comb begin
        rdata = '0;
        if (rd_ok) begin
            case (addr)
                ADDR_W'(OFF_TH_LO): rdata = tohost[HALF_W-1:0];
                ADDR_W'(OFF_TH_HI): rdata = tohost[WORD_W-1:HALF_W];
                ADDR_W'(OFF_FH_LO): rdata = fromhost[HALF_W-1:0];
                ADDR_W'(OFF_FH_HI): rdata = fromhost[WORD_W-1:HALF_W];
                default:            rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hostmbox.sv
// Host-target command mailbox top: register storage, commit handling,
// sticky halt and unsupported-command pulse.
// Assumes single-cycle register accesses; writes are dropped while busy.
module hostmbox
    import hostmbox_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wen,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [1:0]         reg_size,
    input  logic [HALF_W-1:0]  reg_wdata,
    output logic [HALF_W-1:0]  reg_rdata,
    output logic               busy,
    output logic               con_valid,
    output logic [FIELD_W-1:0] con_data,
    input  logic               con_ready,
    output logic               halt,
    output logic               unsup
);
    localparam logic [WORD_W-1:0] ACK_WORD =
        {DEV_CONSOLE, CMD_PUTC, {CMD_LSB{1'b0}}};

    logic [WORD_W-1:0] tohost;
    logic [WORD_W-1:0] fromhost;
    logic [WORD_W-1:0] commit_word;
    logic              size_ok;
    logic              wr;
    logic              commit;
    logic              accept;
    mbox_act_e         act;

    assign size_ok     = (reg_size == SIZE_WORD);
    assign busy        = con_valid;
    assign wr          = reg_wen && size_ok && !busy;
    assign commit      = wr && (reg_addr == ADDR_W'(OFF_TH_HI));
    assign commit_word = {reg_wdata, tohost[HALF_W-1:0]};

    hostmbox_decode u_decode (
        .word (commit_word),
        .act  (act)
    );

    hostmbox_console u_console (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (commit && act == ACT_PUTC),
        .load_byte (commit_word[FIELD_W-1:0]),
        .con_ready (con_ready),
        .con_valid (con_valid),
        .con_data  (con_data),
        .accept    (accept)
    );

    hostmbox_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .tohost   (tohost),
        .fromhost (fromhost),
        .rd_ok    (size_ok),
        .addr     (reg_addr),
        .rdata    (reg_rdata)
    );

    // Command word: half writes, commit result, cleared on console accept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tohost <= '0;
        else if (accept)
            tohost <= '0;
        else if (wr) begin
            if (reg_addr == ADDR_W'(OFF_TH_LO))
                tohost[HALF_W-1:0] <= reg_wdata;
            else if (commit)
                tohost <= (act == ACT_KBD) ? '0 : commit_word;
        end
    end

    // Reply word: half writes, acknowledgement on console accept.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fromhost <= '0;
        else if (accept)
            fromhost <= ACK_WORD;
        else if (wr) begin
            if (reg_addr == ADDR_W'(OFF_FH_LO))
                fromhost[HALF_W-1:0] <= reg_wdata;
            else if (reg_addr == ADDR_W'(OFF_FH_HI))
                fromhost[WORD_W-1:HALF_W] <= reg_wdata;
        end
    end

    // Sticky power-off flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt <= 1'b0;
        else if (commit && act == ACT_HALT)
            halt <= 1'b1;
    end

    // One-cycle pulse for an unrecognised command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unsup <= 1'b0;
        else
            unsup <= commit && act == ACT_BAD;
    end
endmodule

// File: rtl/hostmbox_chk.sv
// Protocol checker for the mailbox ports, bound to every hostmbox instance.
module hostmbox_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        reg_size,
    input logic              con_valid,
    input logic [7:0]        con_data,
    input logic              con_ready,
    input logic              busy,
    input logic              halt,
    input logic              unsup
);
    a_r3_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    a_r4_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid && !con_ready |=> con_valid && $stable(con_data));

    a_r5_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        con_valid && con_ready |=> !con_valid);

    a_r7_unsup_cause: assert property (@(posedge clk) disable iff (!rst_n)
        unsup |-> $past(reg_wen && reg_size == 2'd2 && reg_addr == ADDR_W'(4) && !busy));

    a_r8_no_new_byte_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !con_ready |=> busy);
endmodule

bind hostmbox hostmbox_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_size  (reg_size),
    .con_valid (con_valid),
    .con_data  (con_data),
    .con_ready (con_ready),
    .busy      (busy),
    .halt      (halt),
    .unsup     (unsup)
);

// File: tb/hostmbox_test.sv
// Directed bench for the mailbox: one task per scenario.
module hostmbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [1:0]  reg_size = 2'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        busy, con_valid, halt, unsup;
    logic [7:0]  con_data;
    logic        con_ready = 1'b0;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    hostmbox uut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .con_valid(con_valid), .con_data(con_data),
        .con_ready(con_ready), .halt(halt), .unsup(unsup)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One write cycle; returns at the falling edge after the write edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
        @(negedge clk);
        reg_wen = 1'b0; reg_size = 2'd2;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
        reg_addr = a; reg_size = sz;
        #1 d = reg_rdata;
        reg_size = 2'd2;
    endtask

    task automatic chk_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        chk_reg("R10 tohost lo", 4'd0, 32'h0);
        chk_reg("R10 tohost hi", 4'd4, 32'h0);
        chk_reg("R10 fromhost lo", 4'd8, 32'h0);
        chk_reg("R10 fromhost hi", 4'd12, 32'h0);
        chk("R10 halt", {31'b0, halt}, 32'h0);
        chk("R10 con_valid", {31'b0, con_valid}, 32'h0);
        chk("R10 unsup", {31'b0, unsup}, 32'h0);
    endtask

    task automatic t_map();
        wr(4'd0, 32'hA5A5_1234);
        chk("R2 no unsup", {31'b0, unsup}, 32'h0);
        wr(4'd8, 32'hB0B0_0008);
        wr(4'd12, 32'hC0C0_000C);
        chk_reg("R1 tohost lo", 4'd0, 32'hA5A5_1234);
        chk_reg("R2 tohost hi untouched", 4'd4, 32'h0);
        chk_reg("R1 fromhost lo", 4'd8, 32'hB0B0_0008);
        chk_reg("R1 fromhost hi", 4'd12, 32'hC0C0_000C);
        chk_reg("R1 unmapped 2", 4'd2, 32'h0);
        chk_reg("R1 unmapped 15", 4'd15, 32'h0);
        chk("R2 no console", {31'b0, con_valid}, 32'h0);
        chk("R2 no halt", {31'b0, halt}, 32'h0);
    endtask

    task automatic t_size();
        logic [31:0] d;
        wr(4'd8, 32'hDEAD_BEEF, 2'd1);
        chk_reg("R9 narrow write ignored", 4'd8, 32'hB0B0_0008);
        rd(4'd8, d, 2'd3);
        chk("R9 wide read zero", d, 32'h0);
    endtask

    task automatic t_keyboard();
        wr(4'd0, 32'h0000_0055);
        wr(4'd4, 32'h0100_0000);
        chk("R6 no unsup", {31'b0, unsup}, 32'h0);
        chk("R6 no console", {31'b0, con_valid}, 32'h0);
        chk_reg("R6 tohost lo cleared", 4'd0, 32'h0);
        chk_reg("R6 tohost hi cleared", 4'd4, 32'h0);
        chk_reg("R6 fromhost kept", 4'd12, 32'hC0C0_000C);
    endtask

    task automatic t_unsup();
        wr(4'd0, 32'h0000_0077);
        wr(4'd4, 32'h0102_0000);
        chk("R7 unsup pulse", {31'b0, unsup}, 32'h1);
        chk_reg("R7 tohost hi kept", 4'd4, 32'h0102_0000);
        chk_reg("R7 tohost lo kept", 4'd0, 32'h0000_0077);
        chk_reg("R7 fromhost kept", 4'd8, 32'hB0B0_0008);
        @(negedge clk);
        chk("R7 unsup one cycle", {31'b0, unsup}, 32'h0);
        wr(4'd0, 32'h0000_0002);
        wr(4'd4, 32'h0);
        chk("R3 value 2 no halt", {31'b0, halt}, 32'h0);
        chk("R7 value 2 unsup", {31'b0, unsup}, 32'h1);
    endtask

    task automatic t_console_stall();
        con_ready = 1'b0;
        wr(4'd0, 32'h0000_0041);
        wr(4'd4, 32'h0101_0000);
        chk("R4 valid", {31'b0, con_valid}, 32'h1);
        chk("R4 data", {24'b0, con_data}, 32'h41);
        repeat (3) @(negedge clk);
        chk("R4 held valid", {31'b0, con_valid}, 32'h1);
        chk("R4 held data", {24'b0, con_data}, 32'h41);
        chk_reg("R4 tohost held", 4'd4, 32'h0101_0000);
        wr(4'd8, 32'h1111_1111);
        chk_reg("R8 write while busy ignored", 4'd8, 32'hB0B0_0008);
        // Accept and a write in the same cycle: the write must lose.
        reg_wen = 1'b1; reg_addr = 4'd12; reg_wdata = 32'h2222_2222; con_ready = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0; con_ready = 1'b0;
        chk("R5 valid dropped", {31'b0, con_valid}, 32'h0);
        chk_reg("R8 R5 fromhost hi ack", 4'd12, 32'h0101_0000);
        chk_reg("R5 fromhost lo ack", 4'd8, 32'h0);
        chk_reg("R5 tohost hi cleared", 4'd4, 32'h0);
        chk_reg("R5 tohost lo cleared", 4'd0, 32'h0);
    endtask

    task automatic t_console_fast();
        wr(4'd8, 32'h3);
        con_ready = 1'b1;
        wr(4'd0, 32'h0000_FF5A);
        wr(4'd4, 32'h0101_0000);
        chk("R4 fast valid", {31'b0, con_valid}, 32'h1);
        chk("R4 fast data", {24'b0, con_data}, 32'h5A);
        @(negedge clk);
        chk("R5 fast dropped", {31'b0, con_valid}, 32'h0);
        chk_reg("R5 fast fromhost lo", 4'd8, 32'h0);
        chk_reg("R5 fast tohost lo", 4'd0, 32'h0);
        con_ready = 1'b0;
    endtask

    task automatic t_halt();
        wr(4'd0, 32'h1);
        wr(4'd4, 32'h0);
        chk("R3 halt set", {31'b0, halt}, 32'h1);
        chk("R3 no unsup", {31'b0, unsup}, 32'h0);
        wr(4'd0, 32'h5);
        wr(4'd4, 32'h0100_0000);
        repeat (2) @(negedge clk);
        chk("R3 halt sticky", {31'b0, halt}, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 halt cleared", {31'b0, halt}, 32'h0);
    endtask

    initial begin
        #(4 * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_size();
        t_keyboard();
        t_unsup();
        t_console_stall();
        t_console_fast();
        t_halt();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule